// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands using a single one-bit full adder that is reused on every clock. Both operands are loaded in parallel into two right-shifting registers. Each clock, the two lowest bits and a registered carry go through the full adder. Both registers then move right by one place. The sum bit enters the top of the first register, so that register ends up holding the result where operand A used to be.

A one-cycle start pulse loads both operands and clears the carry flop. A sequencer then allows exactly WIDTH shifts and freezes the datapath. It raises a done flag, which stays high until the next start. The carry flop at that point holds the carry out of the top bit.

The block suits designs where adder area matters more than latency. For the default width of 8, the result is ready eight cycles after the load.

Top module: `serial_accum_adder`

## Requirements
- R1: While rst_i is high at a clock edge, every output goes to zero after that edge: sum_o, carry_o, busy_o and done_o.
- R2: A start_i pulse at a clock edge loads op_a_i into the result register, which sum_o shows after that edge, and op_b_i into the second register. The same edge clears carry_o to 0, sets busy_o to 1 and sets done_o to 0.
- R3: After a load, busy_o stays 1 for exactly WIDTH further clock edges. done_o rises on the WIDTH-th edge, the same edge on which busy_o falls. busy_o and done_o are never both 1.
- R4: When done_o rises, sum_o equals (A + B) mod 2^WIDTH and carry_o equals bit WIDTH of A + B, where A and B are the operands that were loaded.
- R5: Each shift moves the result register right by one place. After k shifts, the upper k bits of sum_o hold the low k bits of A + B, and the lower WIDTH-k bits hold A shifted right by k.
- R6: While done_o is 1 and start_i is 0, sum_o, carry_o and done_o hold their values at every clock edge.
- R7: A start_i pulse while busy_o is 1 discards the addition in progress. It reloads both operands and the carry, and a full WIDTH-cycle addition of the new operands follows.
- R8: The carry of a previous addition never leaks into the next one, because start_i always clears the carry flop.
- R9: start_i takes priority over shifting, and rst_i takes priority over start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that loads the operands and clears the carry |
| op_a_i | input | WIDTH | First operand, parallel load |
| op_b_i | input | WIDTH | Second operand, parallel load |
| sum_o | output | WIDTH | Result register contents; holds the partial or final sum |
| carry_o | output | 1 | Registered carry; the sum's top bit once done_o is 1 |
| busy_o | output | 1 | High while shifting is enabled |
| done_o | output | 1 | High from the final shift until the next start or reset |

## Verification
The bench builds the block with the default WIDTH of 8. At that width, every intermediate register image can be predicted and compared cycle by cycle. The carry chain is tested at its extremes: an all-ones operand plus one ripples a carry through every bit, and all-ones plus all-ones sets the final carry. Restarts in the middle of an addition, resets in the middle of an addition, and long idle holds after done are all reached within a few dozen cycles. The operand pairs are chosen so that a stale carry from one addition would change the next result.

// File: rtl/sa_pkg.sv
package sa_pkg;

    // Result of one full-adder evaluation.
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // Sequencer phases.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

    // One-bit full addition.
    function automatic fa_out_t full_add(input logic x, input logic y, input logic cin);
        fa_out_t r;
        r.sum   = x ^ y ^ cin;
        r.carry = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o,
    output logic             lsb_o
);

    logic [WIDTH-1:0] q_r;

    // Load has priority over shift; reset over both.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_r <= '0;
        end else if (load_i) begin
            q_r <= par_i;
        end else if (shift_i) begin
            q_r <= {ser_i, q_r[WIDTH-1:1]};
        end
    end

    assign q_o   = q_r;
    assign lsb_o = q_r[0];

endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder
    import sa_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);

    fa_out_t res;

    always_comb begin
        res    = full_add(x_i, y_i, cin_i);
        sum_o  = res.sum;
        cout_o = res.carry;
    end

endmodule

// File: rtl/sa_seq.sv
module sa_seq
    import sa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic shift_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    seq_state_t state_r;
    logic [CW-1:0] cnt_r;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_r <= SEQ_IDLE;
            cnt_r   <= '0;
        end else if (start_i) begin
            state_r <= SEQ_RUN;
            cnt_r   <= '0;
        end else if (state_r == SEQ_RUN) begin
            if (cnt_r == LAST) begin
                state_r <= SEQ_DONE;
                cnt_r   <= '0;
            end else begin
                cnt_r <= cnt_r + 1'b1;
            end
        end
    end

    assign shift_o = (state_r == SEQ_RUN) && !start_i;
    assign busy_o  = (state_r == SEQ_RUN);
    assign done_o  = (state_r == SEQ_DONE);

endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
    import sa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             busy_o,
    output logic             done_o
);

    logic             shift_en;
    logic             a_lsb, b_lsb;
    logic             fa_sum, fa_cout;
    logic             carry_r;
    logic [WIDTH-1:0] a_q, b_q;

    sa_seq #(.WIDTH(WIDTH)) seq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .shift_o (shift_en),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    // Operand A / result register: sum bits enter at the top.
    sa_shift_reg #(.WIDTH(WIDTH)) reg_a_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (start_i),
        .shift_i (shift_en),
        .par_i   (op_a_i),
        .ser_i   (fa_sum),
        .q_o     (a_q),
        .lsb_o   (a_lsb)
    );

    // Operand B register: zeros enter at the top.
    sa_shift_reg #(.WIDTH(WIDTH)) reg_b_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (start_i),
        .shift_i (shift_en),
        .par_i   (op_b_i),
        .ser_i   (1'b0),
        .q_o     (b_q),
        .lsb_o   (b_lsb)
    );

    sa_full_adder fa_i (
        .x_i    (a_lsb),
        .y_i    (b_lsb),
        .cin_i  (carry_r),
        .sum_o  (fa_sum),
        .cout_o (fa_cout)
    );

    // Carry flop: cleared by start, updated on each shift.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            carry_r <= 1'b0;
        end else if (start_i) begin
            carry_r <= 1'b0;
        end else if (shift_en) begin
            carry_r <= fa_cout;
        end
    end

    assign sum_o   = a_q;
    assign carry_o = carry_r;

    logic unused_b;
    assign unused_b = ^b_q[WIDTH-1:1];

endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic [WIDTH-1:0] op_a_i,
    input logic [WIDTH-1:0] op_b_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic             busy_o,
    input logic             done_o
);

    logic [WIDTH-1:0] cap_a, cap_b;
    int               steps;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_a <= '0;
            cap_b <= '0;
            steps <= 0;
        end else if (start_i) begin
            cap_a <= op_a_i;
            cap_b <= op_b_i;
            steps <= 0;
        end else if (busy_o) begin
            steps <= steps + 1;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk_i)
        rst_i |=> (sum_o == '0 && !carry_o && !busy_o && !done_o));

    p_start_loads_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (sum_o == $past(op_a_i) && !carry_o && busy_o && !done_o));

    p_done_count_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (steps == WIDTH));

    p_busy_done_excl_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(busy_o && done_o));

    p_result_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_o) |-> ({carry_o, sum_o} == ({1'b0, cap_a} + {1'b0, cap_b})));

    p_shift_right_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !start_i) |=> (sum_o[WIDTH-2:0] == $past(sum_o[WIDTH-1:1])));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> (done_o && $stable(sum_o) && $stable(carry_o)));

endmodule

bind serial_accum_adder sa_checker #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/serial_accum_adder_tb_top.sv
`timescale 1ns/1ps
module serial_accum_adder_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] sum;
    logic         carry, busy, done;

    always #5 clk = ~clk;

    serial_accum_adder #(.WIDTH(W)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .op_a_i  (a_in),
        .op_b_i  (b_in),
        .sum_o   (sum),
        .carry_o (carry),
        .busy_o  (busy),
        .done_o  (done)
    );

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic [W:0] exp_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each completed result against the scoreboard.
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (done && !prev_done) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected result", {23'd0, carry, sum}, 32'hFFFF_FFFF);
            end else begin
                logic [W:0] e;
                e = exp_q.pop_front();
                chk("R4 result", {23'd0, carry, sum}, {23'd0, e});
            end
        end
        prev_done = done;
    end

    // Pulse start at one edge; returns at the negedge after the load.
    task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_q.push_back({1'b0, a} + {1'b0, b});
        pulse_start(a, b);
        chk("R2 load value", {24'd0, sum}, {24'd0, a});
        chk("R2 carry cleared", {31'd0, carry}, 32'd0);
        repeat (W - 1) begin
            @(negedge clk);
            chk("R3 busy during run", {30'd0, busy, done}, 32'd2);
        end
        @(negedge clk);
        chk("R3 done after WIDTH shifts", {30'd0, busy, done}, 32'd1);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; a_in = '0; b_in = '0;
        repeat (2) @(negedge clk);
        chk("R1 reset state", {22'd0, sum, carry, busy, done}, 32'd0);
        rst = 1'b0;

        // R4 several operand patterns
        run_add(8'h12, 8'h34);
        run_add(8'hFF, 8'h01);
        run_add(8'hFF, 8'hFF);
        // R8: preceding run left carry 1
        run_add(8'h00, 8'h00);
        run_add(8'hA5, 8'h5A);

        // R5: track intermediate images
        begin
            int s;
            int a;
            a = 'h5A;
            s = ('h5A + 'h3C) & 'hFF;
            exp_q.push_back(9'h05A + 9'h03C);
            pulse_start(8'h5A, 8'h3C);
            for (int k = 1; k <= W; k++) begin
                int e;
                @(negedge clk);
                e = (((s & ((1 << k) - 1)) << (W - k)) | (a >> k)) & 'hFF;
                chk("R5 partial image", {24'd0, sum}, e);
            end
        end

        // R6: hold after done
        begin
            logic [W-1:0] held;
            logic         hc;
            held = sum;
            hc   = carry;
            a_in = 8'hEE; b_in = 8'h77;
            repeat (5) @(negedge clk);
            chk("R6 hold sum", {24'd0, sum}, {24'd0, held});
            chk("R6 hold carry/done", {30'd0, carry, done}, {30'd0, hc, 1'b1});
        end

        // R7 and R9: restart mid-run (start beats shift)
        pulse_start(8'hF0, 8'hF0);
        repeat (3) @(negedge clk);
        exp_q.push_back(9'h033 + 9'h044);
        run_add(8'h33, 8'h44);

        // R8: restart mid-run while carry flop is 1
        pulse_start(8'hFF, 8'hFF);
        @(negedge clk);
        chk("R8 carry set mid-run", {31'd0, carry}, 32'd1);
        void'(exp_q.pop_back());
        run_add(8'h01, 8'h02);

        // R9: reset beats start, and reset mid-run
        pulse_start(8'h77, 8'h11);
        repeat (2) @(negedge clk);
        rst = 1'b1; start = 1'b1; a_in = 8'h99;
        @(negedge clk);
        chk("R9 reset over start", {22'd0, sum, carry, busy, done}, 32'd0);
        rst = 1'b0; start = 1'b0;
        run_add(8'h80, 8'h80);

        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 32'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule